// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block watches an I2C bus from the slave side and keeps one byte of status flags that firmware can read. Its SCL and SDA inputs are already synchronised to the fast system clock. Each clock it compares them with a registered copy of the previous sample. From that comparison it finds SCL edges and the Start and Stop conditions.

After each Start it collects the first byte and compares it with the slave's own address. Both 7-bit and 10-bit addressing are supported. When the address matches, it keeps following the transfer's data bytes. It records whether the most recent byte was an address or data, the direction bit of the matched address, and whether the buffer is full. In 10-bit mode it also raises a request for firmware to reload the address register.

The block only observes the bus. It drives no ACK and never stretches the clock. Two configuration bits, slew control and SMBus input select, can be written and are only stored. They have no effect on the bus logic.

Top module: `i2c_slave_status`

## Requirements
- R1: `status` is {slew_cfg[7], smbus_cfg[6], data_flag[5], stop_flag[4], start_flag[3], rw_flag[2], upd_flag[1], full_flag[0]}. All bits are 0 after reset. A `cfg_wr` pulse loads bit 7 from `cfg_wdata[1]` and bit 6 from `cfg_wdata[0]`. A write changes no other bit.
- R2: SDA falling while SCL is high is a Start. It sets `start_flag` and clears `stop_flag`, and a repeated Start does the same. SDA rising while SCL is high is a Stop. It sets `stop_flag` and clears `start_flag`. The two flags are never 1 together.
- R3: While `en` is 0, `start_flag` and `stop_flag` are held at 0. No Start or Stop is detected in that time, and byte tracking is idle.
- R4: In 7-bit mode (`mode10`=0), the first byte after a Start matches when bits [7:1] equal `own_addr[6:0]`. A match copies bit 0 (1 = read) into `rw_flag`, clears `data_flag` and sets `full_flag`. A mismatch changes none of these flags, and every byte is then ignored until the next Start.
- R5: In a matched write transfer, the eighth rising SCL edge of each data byte sets `data_flag` and `full_flag`. A `buf_rd` pulse clears `full_flag`.
- R6: In a matched read transfer, a `tx_load` pulse sets `full_flag`. It stays 1 while the eight data bits are clocked. It is cleared on the SCL falling edge that ends the eighth data bit, and `data_flag` becomes 1 for that byte.
- R7: `rw_flag` is cleared by a Start, by a Stop, and by a NACK. A NACK is SDA high at the ninth rising SCL edge of a tracked byte. A NACK also ends tracking until the next Start.
- R8: In 10-bit mode a first byte of 11110,a9,a8,0 matches when a9,a8 equal `own_addr[9:8]`. A match sets `upd_flag`, clears `rw_flag` and `data_flag`, and sets `full_flag`. A second byte equal to `own_addr[7:0]` sets `upd_flag` again and starts a write transfer. A `addr_wr` pulse clears `upd_flag`. A second byte that does not match leaves `upd_flag` and `full_flag` unchanged.
- R9: Once a full 10-bit address has matched, a repeated Start with first byte 11110,a9,a8,1 starts a read transfer. It sets `rw_flag` and `full_flag` and leaves `upd_flag` alone. A Stop or a NACK forgets the full match, so this header then does not match.
- R10: In 7-bit mode `upd_flag` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable |
| scl | input | 1 | Synchronised SCL |
| sda | input | 1 | Synchronised SDA |
| mode10 | input | 1 | 1 = 10-bit addressing |
| own_addr | input | 10 | Slave address (7-bit mode uses [6:0]) |
| addr_wr | input | 1 | Firmware wrote the address register |
| cfg_wr | input | 1 | Write strobe for the configuration bits |
| cfg_wdata | input | 2 | {slew, smbus} configuration value |
| buf_rd | input | 1 | Firmware read the buffer |
| tx_load | input | 1 | Firmware loaded the transmit buffer |
| status | output | 8 | Packed status byte |
| slew_cfg | output | 1 | Stored slew-control bit |
| smbus_cfg | output | 1 | Stored SMBus-select bit |
| data_flag | output | 1 | Last byte was data (1) or address (0) |
| stop_flag | output | 1 | Last condition was Stop |
| start_flag | output | 1 | Last condition was Start |
| rw_flag | output | 1 | Direction of matched address, 1 = read |
| upd_flag | output | 1 | 10-bit address update request |
| full_flag | output | 1 | Buffer full |

## Verification
The design compares each input sample with its registered copy from the previous clock. A Start, a Stop or an SCL edge therefore changes the flags at the first clock edge after the line changes. The result is visible one cycle later. Firmware strobes (`cfg_wr`, `buf_rd`, `tx_load`, `addr_wr`) take effect one cycle after they are sampled. The bench changes each bus line, then waits four clocks before the next change or any check. It samples outputs on the falling clock edge, so every check sees settled values. Its mid-byte checks of the transmit buffer-full flag land between the seventh and eighth bits and again after the closing SCL fall.

// File: rtl/i2c_slave_status.sv
module i2c_slave_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       scl,
  input  logic       sda,
  input  logic       mode10,
  input  logic [9:0] own_addr,
  input  logic       addr_wr,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_wdata,
  input  logic       buf_rd,
  input  logic       tx_load,
  output logic [7:0] status,
  output logic       slew_cfg,
  output logic       smbus_cfg,
  output logic       data_flag,
  output logic       stop_flag,
  output logic       start_flag,
  output logic       rw_flag,
  output logic       upd_flag,
  output logic       full_flag
);

  typedef enum logic [2:0] {PH_IDLE, PH_HDR, PH_LOW, PH_WR, PH_RD} ph_t;

  ph_t        ph;
  logic       scl_q, sda_q, ten_hit;
  logic [3:0] cnt;
  logic [7:0] sh;

  wire start_ev = en & scl & scl_q & sda_q & ~sda;
  wire stop_ev  = en & scl & scl_q & ~sda_q & sda;
  wire scl_rise = en & scl & ~scl_q;
  wire scl_fall = en & ~scl & scl_q;
  wire busy     = (ph != PH_IDLE);
  wire ack_ev   = scl_rise & busy & (cnt == 4'd8);
  wire nack_ev  = ack_ev & sda;
  wire tx_done  = scl_fall & (ph == PH_RD) & (cnt == 4'd8) & data_flag;

  wire [7:0] byte_in = {sh[6:0], sda};
  wire hdr_ok = (byte_in[7:3] == 5'b11110) && (byte_in[2:1] == own_addr[9:8]);
  wire m7     = !mode10 && (byte_in[7:1] == own_addr[6:0]);
  wire m10w   = mode10 && hdr_ok && !byte_in[0];
  wire m10r   = mode10 && hdr_ok && byte_in[0] && ten_hit;
  wire mlow   = (byte_in == own_addr[7:0]);

  assign status = {slew_cfg, smbus_cfg, data_flag, stop_flag,
                   start_flag, rw_flag, upd_flag, full_flag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      ph         <= PH_IDLE;
      cnt        <= 4'd0;
      sh         <= 8'd0;
      ten_hit    <= 1'b0;
      slew_cfg   <= 1'b0;
      smbus_cfg  <= 1'b0;
      data_flag  <= 1'b0;
      stop_flag  <= 1'b0;
      start_flag <= 1'b0;
      rw_flag    <= 1'b0;
      upd_flag   <= 1'b0;
      full_flag  <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (cfg_wr) {slew_cfg, smbus_cfg} <= cfg_wdata;
      if (addr_wr) upd_flag <= 1'b0;
      if (buf_rd) full_flag <= 1'b0;
      if (tx_load && ph == PH_RD) full_flag <= 1'b1;

      if (!en) begin
        ph         <= PH_IDLE;
        cnt        <= 4'd0;
        ten_hit    <= 1'b0;
        start_flag <= 1'b0;
        stop_flag  <= 1'b0;
      end else if (start_ev) begin
        start_flag <= 1'b1;
        stop_flag  <= 1'b0;
        rw_flag    <= 1'b0;
        ph         <= PH_HDR;
        cnt        <= 4'd0;
      end else if (stop_ev) begin
        stop_flag  <= 1'b1;
        start_flag <= 1'b0;
        rw_flag    <= 1'b0;
        ten_hit    <= 1'b0;
        ph         <= PH_IDLE;
        cnt        <= 4'd0;
      end else if (scl_rise && busy) begin
        if (cnt == 4'd8) begin
          cnt <= 4'd0;
          if (sda) begin
            rw_flag <= 1'b0;
            ten_hit <= 1'b0;
            ph      <= PH_IDLE;
          end
        end else begin
          sh  <= byte_in;
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            case (ph)
              PH_HDR: begin
                if (m7) begin
                  ph        <= byte_in[0] ? PH_RD : PH_WR;
                  rw_flag   <= byte_in[0];
                  data_flag <= 1'b0;
                  full_flag <= 1'b1;
                end else if (m10w) begin
                  ph        <= PH_LOW;
                  rw_flag   <= 1'b0;
                  data_flag <= 1'b0;
                  full_flag <= 1'b1;
                  upd_flag  <= 1'b1;
                end else if (m10r) begin
                  ph        <= PH_RD;
                  rw_flag   <= 1'b1;
                  data_flag <= 1'b0;
                  full_flag <= 1'b1;
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_LOW: begin
                if (mlow) begin
                  ph        <= PH_WR;
                  ten_hit   <= 1'b1;
                  data_flag <= 1'b0;
                  full_flag <= 1'b1;
                  upd_flag  <= 1'b1;
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_WR: begin
                data_flag <= 1'b1;
                full_flag <= 1'b1;
              end
              PH_RD: data_flag <= 1'b1;
              default: ;
            endcase
          end
        end
      end else if (tx_done) begin
        full_flag <= 1'b0;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_flag && stop_flag)); // R2
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> start_flag && !stop_flag); // R2
  AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> stop_flag && !start_flag); // R2
  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !start_flag && !stop_flag); // R3
  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> {slew_cfg, smbus_cfg} == $past(cfg_wdata)); // R1
  AST_STOP_RW: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !rw_flag); // R7
  AST_NACK_RW: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ev |=> !rw_flag); // R7
  AST_UPD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_flag) |-> $past(mode10)); // R10

endmodule

// File: tb/i2c_slave_status_tb.sv
`timescale 1ns/1ps
module i2c_slave_status_tb;
  logic clk = 0, rst_n = 0, en = 1, scl = 1, sda = 1, mode10 = 0;
  logic [9:0] own_addr = 10'h052;
  logic addr_wr = 0, cfg_wr = 0, buf_rd = 0, tx_load = 0;
  logic [1:0] cfg_wdata = 0;
  logic [7:0] status;
  logic slew_cfg, smbus_cfg, data_flag, stop_flag, start_flag, rw_flag, upd_flag, full_flag;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_slave_status u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wq(); repeat (4) @(negedge clk); endtask
  task automatic pulse(ref logic s); @(negedge clk); s = 1; @(negedge clk); s = 0; wq(); endtask
  task automatic do_start(); sda = 1; wq(); scl = 1; wq(); sda = 0; wq(); scl = 0; wq(); endtask
  task automatic do_stop(); sda = 0; wq(); scl = 1; wq(); sda = 1; wq(); endtask
  task automatic send_bit(input logic b); sda = b; wq(); scl = 1; wq(); wq(); scl = 0; wq(); endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic t_reset();
    chk("R1 reset status", status, 8'h00);
  endtask

  task automatic t_cfg();
    cfg_wdata = 2'b10; pulse(cfg_wr);
    chk("R1 cfg write 10", status, 8'h80);
    cfg_wdata = 2'b01; pulse(cfg_wr);
    chk("R1 cfg write 01", status, 8'h40);
    cfg_wdata = 2'b00; pulse(cfg_wr);
    chk("R1 cfg write 00", status, 8'h00);
  endtask

  task automatic t_cond();
    do_start();
    chk("R2 start flags", {start_flag, stop_flag}, 8'h02);
    do_stop();
    chk("R2 stop flags", {start_flag, stop_flag}, 8'h01);
    do_start(); sda = 1; wq(); do_start();
    chk("R2 repeated start", {start_flag, stop_flag}, 8'h02);
    do_stop();
  endtask

  task automatic t_enable();
    do_start();
    en = 0; wq();
    chk("R3 disable clears", {start_flag, stop_flag}, 8'h00);
    do_start();
    chk("R3 start ignored", {start_flag, stop_flag}, 8'h00);
    do_stop();
    chk("R3 stop ignored", {start_flag, stop_flag}, 8'h00);
    en = 1; wq();
    chk("R3 re-enable quiet", {start_flag, stop_flag}, 8'h00);
  endtask

  task automatic t_write7();
    do_start(); send_byte(8'hA4); send_bit(0);
    chk("R4 write addr match", status, 8'h09);
    pulse(buf_rd);
    chk("R5 buf read clears", full_flag, 8'h00);
    send_byte(8'h3C); send_bit(0);
    chk("R5 data byte", status, 8'h29);
    pulse(buf_rd);
    do_stop();
    chk("R7 stop status", status, 8'h30);
    chk("R10 ua in 7-bit", upd_flag, 8'h00);
  endtask

  task automatic t_mismatch();
    do_start(); send_byte(8'h27); send_bit(0);
    chk("R4 mismatch no change", status, 8'h28);
    send_byte(8'hFF); send_bit(0);
    chk("R4 later byte ignored", status, 8'h28);
    do_stop();
  endtask

  task automatic t_read7();
    do_start(); send_byte(8'hA5); send_bit(0);
    chk("R4 read addr match", status, 8'h0D);
    pulse(buf_rd);
    pulse(tx_load);
    chk("R6 tx load sets full", full_flag, 8'h01);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    chk("R6 full while shifting", {data_flag, full_flag}, 8'h01);
    send_bit(1'b0);
    chk("R6 full clears after 8th bit", {data_flag, full_flag}, 8'h02);
    send_bit(0);
    chk("R7 ack keeps rw", rw_flag, 8'h01);
    pulse(tx_load);
    send_byte(8'h55); send_bit(1);
    chk("R7 nack clears rw", rw_flag, 8'h00);
    do_start(); send_byte(8'hA5); send_bit(0);
    chk("R7 rw set again", rw_flag, 8'h01);
    do_start();
    chk("R7 start clears rw", rw_flag, 8'h00);
    do_stop();
    pulse(buf_rd);
  endtask

  task automatic t_ten();
    mode10 = 1; own_addr = 10'h2B6;
    do_start(); send_byte(8'hF4); send_bit(0);
    chk("R8 header match", {upd_flag, rw_flag, data_flag, full_flag}, 8'h09);
    pulse(addr_wr);
    chk("R8 addr write clears ua", upd_flag, 8'h00);
    pulse(buf_rd);
    send_byte(8'hB6); send_bit(0);
    chk("R8 low byte match", {upd_flag, full_flag}, 8'h03);
    pulse(addr_wr); pulse(buf_rd);
    do_start(); send_byte(8'hF5); send_bit(0);
    chk("R9 read header", {upd_flag, rw_flag, full_flag}, 8'h03);
    pulse(buf_rd); pulse(tx_load);
    send_byte(8'h81); send_bit(1);
    chk("R9 nack after read", rw_flag, 8'h00);
    do_stop();
    do_start(); send_byte(8'hF5); send_bit(0);
    chk("R9 header without memory", {rw_flag, full_flag}, 8'h00);
    do_stop();
    do_start(); send_byte(8'hF4); send_bit(0);
    pulse(addr_wr); pulse(buf_rd);
    send_byte(8'hB7); send_bit(0);
    chk("R8 low byte mismatch", {upd_flag, full_flag}, 8'h00);
    do_stop();
    mode10 = 0; own_addr = 10'h052;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    wq();
    t_reset();
    t_cfg();
    t_cond();
    t_enable();
    t_write7();
    t_mismatch();
    t_read7();
    t_ten();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule